// File: doc/BRIEF.md
# DDR2 Burst Latency Scheduler

This block sits beside the command path of a double-data-rate memory controller. It decides in which clock cycles data belongs on the bus after a column command. Three settings drive it: a CAS latency, an additive (posted-CAS) latency and a burst length.

Each accepted read or write books a run of consecutive cycles on an internal timeline. As those cycles come round, the block raises a read-capture enable, or a write-drive enable together with the per-byte write mask. Two beats move in each cycle, one on each clock edge. A burst of 4 therefore spans 2 cycles and a burst of 8 spans 4.

Commands spaced by half the burst length chain into one unbroken strobe. A command whose data window would land on cycles already booked is refused and flagged. The latency settings are frozen while any burst is still pending.

Top module: `ddr_burst_sched`

## Requirements
- R1: After reset all outputs are 0, and the settings are CAS latency 3, additive latency 0 and burst of 4.
- R2: For an accepted read presented in cycle 0, `rd_capture_en` is 1 in cycles AL+CL through AL+CL+BL/2-1 and in no other cycle because of that read.
- R3: For an accepted write presented in cycle 0, `wr_drive_en` is 1 in cycles AL+CL-1 through AL+CL+BL/2-2, one cycle earlier than a read would be.
- R4: `cfg_bl8`=1 selects a burst of 8, which gives 4 strobe cycles; `cfg_bl8`=0 selects a burst of 4, which gives 2 strobe cycles.
- R5: While `wr_drive_en` is 1, `wr_dm` carries the `cmd_dm` of that write, where bit i set means byte lane i is masked and must not be written. In every other cycle `wr_dm` is 0, including during reads.
- R6: Commands presented BL/2 cycles apart are all accepted, and their strobes join with no gap cycle.
- R7: A command whose data cycles overlap any cycle already booked, for example a read landing on a scheduled write burst, is rejected. `cmd_err` is 1 in the cycle after the command, and the command books nothing.
- R8: A settings write (`cfg_we`=1) takes effect at the next edge only if no cycle is booked and no command is presented in the same cycle. Otherwise it is ignored, and a command presented together with it uses the old settings.
- R9: A settings write with `cfg_cl` outside 3..5, or with `cfg_al` above AL_MAX (default 4), is ignored.
- R10: `rd_capture_en` and `wr_drive_en` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Settings write strobe |
| cfg_cl | input | 3 | CAS latency in cycles (3..5) |
| cfg_al | input | 3 | Additive latency in cycles (0..AL_MAX) |
| cfg_bl8 | input | 1 | 1 = burst of 8, 0 = burst of 4 |
| cmd_valid | input | 1 | Column command present this cycle |
| cmd_is_wr | input | 1 | 1 = write, 0 = read |
| cmd_dm | input | MASK_W | Per-byte write mask for the burst (1 = masked) |
| rd_capture_en | output | 1 | Read data capture cycle |
| wr_drive_en | output | 1 | Write data drive cycle |
| wr_dm | output | MASK_W | Byte mask during write drive cycles |
| cmd_err | output | 1 | Previous cycle's command was rejected |

## Verification
Two things can fall in the same cycle, and the bench provokes both.

The first is a settings write arriving together with a column command. The bench presents both in one cycle on an idle timeline. It expects the command's strobes at the old latency. It then checks that a later lone read still uses the old latency, which shows the settings write was dropped.

The second is a new command whose data window lands on an already booked burst. The bench issues a write and then a read one cycle later, so the read's capture cycles overlap the write's drive cycles. It expects `cmd_err` and expects no extra strobe from the read. It also runs the mirror case, a write landing on a read, at the largest latency setting.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  localparam int CL_LO   = 3;
  localparam int CL_HI   = 5;
  localparam int BL4_CYC = 2;
  localparam int BL8_CYC = 4;

  typedef enum logic {
    BURST4 = 1'b0,
    BURST8 = 1'b1
  } burst_e;
endpackage

// File: rtl/dbs_latcfg.sv
module dbs_latcfg import dbs_pkg::*; #(
  parameter int AL_MAX = 4,
  parameter int AL_W   = 3,
  parameter int LAT_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_cl,
  input  logic [AL_W-1:0]  cfg_al,
  input  logic             cfg_bl8,
  input  logic             busy,
  output logic [LAT_W-1:0] rd_lat,
  output logic [LAT_W-1:0] wr_lat,
  output logic [LAT_W-1:0] burst_cyc
);
  logic [2:0]      cl_q;
  logic [AL_W-1:0] al_q;
  burst_e          bl_q;
  logic            legal;

  assign legal = (int'(cfg_cl) >= CL_LO) && (int'(cfg_cl) <= CL_HI) &&
                 (int'(cfg_al) <= AL_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cl_q <= 3'(CL_LO);
      al_q <= '0;
      bl_q <= BURST4;
    end else if (cfg_we && !busy && legal) begin
      cl_q <= cfg_cl;
      al_q <= cfg_al;
      bl_q <= cfg_bl8 ? BURST8 : BURST4;
    end
  end

  assign rd_lat    = LAT_W'(cl_q) + LAT_W'(al_q);
  assign wr_lat    = rd_lat - LAT_W'(1);
  assign burst_cyc = (bl_q == BURST8) ? LAT_W'(BL8_CYC) : LAT_W'(BL4_CYC);

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable({cl_q, al_q, bl_q})); // R8
  AST_CL_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (int'(cl_q) >= CL_LO) && (int'(cl_q) <= CL_HI) && (int'(al_q) <= AL_MAX)); // R9
endmodule

// File: rtl/dbs_timeline.sv
module dbs_timeline #(
  parameter int DEPTH  = 12,
  parameter int MASK_W = 2,
  parameter int LAT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ins_req,
  input  logic              ins_wr,
  input  logic [MASK_W-1:0] ins_dm,
  input  logic [LAT_W-1:0]  ins_lat,
  input  logic [LAT_W-1:0]  ins_len,
  output logic              ins_hit,
  output logic              busy,
  output logic              head_vld,
  output logic              head_wr,
  output logic [MASK_W-1:0] head_dm
);
  // slot i (before an edge) holds the cycle i+1 ahead of the current one
  logic [DEPTH-1:0]  vld_q, wr_q, vld_nx, wr_nx, probe, fill;
  logic [MASK_W-1:0] dm_q  [DEPTH];
  logic [MASK_W-1:0] dm_nx [DEPTH];
  logic              take;

  assign take = ins_req && !ins_hit;

  genvar i;
  generate
    for (i = 0; i < DEPTH; i++) begin : g_slot
      assign probe[i] = (i + 1 >= int'(ins_lat)) &&
                        (i + 1 <  int'(ins_lat) + int'(ins_len));
      assign fill[i]  = (i + 2 >= int'(ins_lat)) &&
                        (i + 2 <  int'(ins_lat) + int'(ins_len));
      if (i == DEPTH - 1) begin : g_tail
        assign vld_nx[i] = take && fill[i];
        assign wr_nx[i]  = take && fill[i] && ins_wr;
        assign dm_nx[i]  = (take && fill[i]) ? ins_dm : '0;
      end else begin : g_body
        assign vld_nx[i] = (take && fill[i]) ? 1'b1   : vld_q[i+1];
        assign wr_nx[i]  = (take && fill[i]) ? ins_wr : wr_q[i+1];
        assign dm_nx[i]  = (take && fill[i]) ? ins_dm : dm_q[i+1];
      end
    end
  endgenerate

  assign ins_hit = ins_req && |(probe & vld_q);
  assign busy    = |vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q    <= '0;
      wr_q     <= '0;
      head_vld <= 1'b0;
      head_wr  <= 1'b0;
      head_dm  <= '0;
      for (int k = 0; k < DEPTH; k++) dm_q[k] <= '0;
    end else begin
      vld_q    <= vld_nx;
      wr_q     <= wr_nx;
      head_vld <= vld_q[0];
      head_wr  <= vld_q[0] && wr_q[0];
      head_dm  <= (vld_q[0] && wr_q[0]) ? dm_q[0] : '0;
      for (int k = 0; k < DEPTH; k++) dm_q[k] <= dm_nx[k];
    end
  end

  AST_BOOKED_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
    (ins_req && !ins_hit) |=> busy); // R2
endmodule

// File: rtl/ddr_burst_sched.sv
module ddr_burst_sched import dbs_pkg::*; #(
  parameter int MASK_W = 2,
  parameter int AL_MAX = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              cfg_we,
  input  logic [2:0]                        cfg_cl,
  input  logic [$clog2(AL_MAX+1)-1:0]       cfg_al,
  input  logic                              cfg_bl8,
  input  logic                              cmd_valid,
  input  logic                              cmd_is_wr,
  input  logic [MASK_W-1:0]                 cmd_dm,
  output logic                              rd_capture_en,
  output logic                              wr_drive_en,
  output logic [MASK_W-1:0]                 wr_dm,
  output logic                              cmd_err
);
  localparam int AL_W  = $clog2(AL_MAX + 1);
  localparam int DEPTH = CL_HI + AL_MAX + BL8_CYC - 1;
  localparam int LAT_W = $clog2(DEPTH + 2);

  logic [LAT_W-1:0]  rd_lat, wr_lat, burst_cyc, lat_sel;
  logic              hit, tl_busy, h_vld, h_wr;
  logic [MASK_W-1:0] h_dm;

  dbs_latcfg #(.AL_MAX(AL_MAX), .AL_W(AL_W), .LAT_W(LAT_W)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_cl(cfg_cl), .cfg_al(cfg_al),
    .cfg_bl8(cfg_bl8), .busy(tl_busy || cmd_valid),
    .rd_lat(rd_lat), .wr_lat(wr_lat), .burst_cyc(burst_cyc)
  );

  assign lat_sel = cmd_is_wr ? wr_lat : rd_lat;

  dbs_timeline #(.DEPTH(DEPTH), .MASK_W(MASK_W), .LAT_W(LAT_W)) u_tl (
    .clk(clk), .rst(rst), .ins_req(cmd_valid), .ins_wr(cmd_is_wr),
    .ins_dm(cmd_is_wr ? cmd_dm : '0), .ins_lat(lat_sel), .ins_len(burst_cyc),
    .ins_hit(hit), .busy(tl_busy),
    .head_vld(h_vld), .head_wr(h_wr), .head_dm(h_dm)
  );

  always_ff @(posedge clk) begin
    if (rst) cmd_err <= 1'b0;
    else     cmd_err <= cmd_valid && hit;
  end

  assign rd_capture_en = h_vld && !h_wr;
  assign wr_drive_en   = h_wr;
  assign wr_dm         = h_dm;

  AST_NO_BOTH_DIR: assert property (@(posedge clk) disable iff (rst)
    !(rd_capture_en && wr_drive_en)); // R10
  AST_DM_ONLY_WR: assert property (@(posedge clk) disable iff (rst)
    (wr_dm != '0) |-> wr_drive_en); // R5
  AST_ERR_HAS_CMD: assert property (@(posedge clk) disable iff (rst)
    cmd_err |-> $past(cmd_valid)); // R7
  AST_BURST_MIN: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_capture_en) |=> rd_capture_en); // R4
endmodule

// File: tb/ddr_burst_sched_tb.sv
module ddr_burst_sched_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst = 1'b1, cfg_we = 1'b0, cfg_bl8 = 1'b0;
  logic [2:0] cfg_cl = 3'd3, cfg_al = 3'd0;
  logic       cmd_valid = 1'b0, cmd_is_wr = 1'b0;
  logic [1:0] cmd_dm = 2'b00;
  logic       rd_capture_en, wr_drive_en, cmd_err;
  logic [1:0] wr_dm;

  ddr_burst_sched u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_cl(cfg_cl), .cfg_al(cfg_al),
    .cfg_bl8(cfg_bl8), .cmd_valid(cmd_valid), .cmd_is_wr(cmd_is_wr),
    .cmd_dm(cmd_dm), .rd_capture_en(rd_capture_en), .wr_drive_en(wr_drive_en),
    .wr_dm(wr_dm), .cmd_err(cmd_err)
  );

  typedef struct {
    int       cyc;
    bit       wr;
    bit [1:0] dm;
    string    tag;
  } beat_t;

  beat_t exp_q[$];
  int    cyc = 0, checks = 0, errors = 0;
  int    cur_rl = 3, cur_n = 2;
  bit    mon_on = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, expv, cyc);
    end
  endtask

  // monitor: pops the beat booked for this cycle, else expects idle
  always @(negedge clk) begin
    bit e_rd, e_wr;
    bit [1:0] e_dm;
    string tg;
    int h;
    if (mon_on) begin
      e_rd = 0; e_wr = 0; e_dm = 0; tg = "R7"; h = -1;
      foreach (exp_q[k]) if (exp_q[k].cyc == cyc) h = k;
      if (h >= 0) begin
        e_rd = !exp_q[h].wr;
        e_wr = exp_q[h].wr;
        e_dm = exp_q[h].dm;
        tg   = exp_q[h].tag;
        exp_q.delete(h);
      end
      chk(rd_capture_en == e_rd, tg, "rd_capture_en", int'(rd_capture_en), int'(e_rd));
      chk(wr_drive_en == e_wr, tg, "wr_drive_en", int'(wr_drive_en), int'(e_wr));
      chk(wr_dm == e_dm, (h >= 0) ? tg : "R5", "wr_dm", int'(wr_dm), int'(e_dm));
      chk(!(rd_capture_en && wr_drive_en), "R10", "both enables", 1, 0);
    end
  end

  task automatic issue(bit wr, bit [1:0] dm, bit exp_err, string tag);
    int p;
    p = cyc;
    cmd_valid = 1'b1; cmd_is_wr = wr; cmd_dm = dm;
    if (!exp_err)
      for (int k = 0; k < cur_n; k++)
        exp_q.push_back('{p + (wr ? cur_rl - 1 : cur_rl) + k, wr, wr ? dm : 2'b00, tag});
    @(negedge clk);
    cmd_valid = 1'b0; cmd_dm = 2'b00;
    chk(cmd_err == exp_err, exp_err ? "R7" : tag, "cmd_err", int'(cmd_err), int'(exp_err));
  endtask

  task automatic cfg(int cl, int al, bit bl8, bit applies);
    cfg_we = 1'b1; cfg_cl = 3'(cl); cfg_al = 3'(al); cfg_bl8 = bl8;
    @(negedge clk);
    cfg_we = 1'b0;
    if (applies) begin
      cur_rl = cl + al;
      cur_n  = bl8 ? 4 : 2;
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(3);
    chk(!rd_capture_en && !wr_drive_en && wr_dm == 0 && !cmd_err, "R1", "outputs in reset", 1, 0);
    rst = 1'b0;
    idle(1);
    chk(!rd_capture_en && !wr_drive_en && wr_dm == 0 && !cmd_err, "R1", "outputs after reset", 1, 0);
    mon_on = 1'b1;

    // R1 default latency 3, burst of 4; R2 read window
    issue(1'b0, 2'b11, 1'b0, "R1");
    idle(12);
    // R3 write one cycle earlier; R5 mask per lane; R6 seamless writes
    issue(1'b1, 2'b01, 1'b0, "R3");
    idle(1);
    issue(1'b1, 2'b10, 1'b0, "R5");
    idle(12);
    // R4 burst of 8 with AL=2, CL=4; R6 reads 4 cycles apart run together
    cfg(4, 2, 1'b1, 1'b1);
    issue(1'b0, 2'b00, 1'b0, "R4");
    idle(3);
    issue(1'b0, 2'b00, 1'b0, "R6");
    idle(3);
    issue(1'b0, 2'b00, 1'b0, "R6");
    idle(16);
    // R7 read landing on a booked write is refused, later read accepted
    issue(1'b1, 2'b11, 1'b0, "R7");
    issue(1'b0, 2'b00, 1'b1, "R7");
    idle(2);
    issue(1'b0, 2'b00, 1'b0, "R7");
    idle(16);
    // R8 settings write while busy is ignored
    issue(1'b0, 2'b00, 1'b0, "R8");
    cfg(5, 0, 1'b0, 1'b0);
    idle(14);
    issue(1'b0, 2'b00, 1'b0, "R8");
    idle(14);
    // R8 settings write in the same cycle as a command is ignored
    cfg_we = 1'b1; cfg_cl = 3'd3; cfg_al = 3'd0; cfg_bl8 = 1'b0;
    issue(1'b0, 2'b00, 1'b0, "R8");
    cfg_we = 1'b0;
    idle(14);
    issue(1'b0, 2'b00, 1'b0, "R8");
    idle(14);
    // R9 illegal CL or AL is ignored
    cfg(2, 0, 1'b0, 1'b0);
    cfg(4, 5, 1'b0, 1'b0);
    issue(1'b0, 2'b00, 1'b0, "R9");
    idle(14);
    // largest latency, burst of 4: RL=9, WL=8
    cfg(5, 4, 1'b0, 1'b1);
    issue(1'b0, 2'b00, 1'b0, "R2");
    issue(1'b1, 2'b01, 1'b1, "R7");
    idle(14);
    issue(1'b1, 2'b10, 1'b0, "R3");
    idle(1);
    issue(1'b1, 2'b11, 1'b0, "R6");
    idle(16);
    chk(exp_q.size() == 0, "R2", "unserved beats", exp_q.size(), 0);
    finish_run();
  end
endmodule